// File: doc/BRIEF.md
# Transmit Packet Page Allocator

This block keeps track of a shared packet memory split into equal pages. A host processor and a MAC transmit engine share that memory. The host asks for buffer space with an allocate command that carries a byte count. The block finds a contiguous run of free pages and reports the index of the first page as the packet number. It then sets a completion status bit, which can drive an interrupt line. The host writes that number into a packet-number register and issues an enqueue command. This hands the number to a small transmit queue. The MAC drains that queue only while transmission is allowed.

Pages return to the pool when the MAC signals, through a release port, that a packet has gone out. A clear command drops every allocation and every queued number at once. Only packet numbers move through the block. The packet data, its address pointers and the MAC itself live elsewhere.

The controller has three states. IDLE accepts commands. ALLOC_WAIT searches for pages every cycle. CLEAR is a one-cycle state entered after a clear command. The transitions are:
- IDLE→ALLOC_WAIT on an allocate command.
- ALLOC_WAIT→IDLE when a run of pages is found (commit).
- ALLOC_WAIT→ALLOC_WAIT while no run fits, or when a new allocate command restarts the search.
- any state→CLEAR on a clear command.
- CLEAR→IDLE after one cycle.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset: busy, done, irq, result_fail, tx_ovf and mac_valid are 0, and all pages are free.
- R2: An allocate command (cmd_op=1) reserves ceil(alloc_bytes/PAGE_BYTES) pages, or at least one page, as the lowest-indexed contiguous free run. busy is 1 after the command edge. At the second edge, result_pn holds the first page index, done is 1 and busy is 0.
- R3: While no free run is large enough, the request stays pending: busy=1, done=0, result_fail=1. It completes on its own once releases free enough pages.
- R4: irq equals done while irq_en=1, and stays 0 while irq_en=0.
- R5: done is cleared by a new allocate command or by a pulse on ack_wr.
- R6: An enqueue command (cmd_op=2) pushes the value of the packet-number register, loaded by pnum_wr, into the transmit queue. The MAC receives the numbers in the order they were enqueued.
- R7: mac_valid is 1 only when the queue is non-empty, tx_en=1, and either half_duplex=0 or defer_ok=1. An entry is taken when mac_valid and mac_ready are both 1.
- R8: An enqueue into a full queue (FIFO_DEPTH entries) is dropped and sets tx_ovf. tx_ovf stays set until a clear command.
- R9: A release of a packet number frees all pages of that packet. A release of a number that is not the first page of a live packet changes nothing.
- R10: A clear command (cmd_op=3) frees every page, empties the queue, clears tx_ovf, done and result_fail, and holds busy for exactly one cycle.
- R11: Command codes 0 and 4 to 7 change no state.
- R12: A new allocate command abandons a pending request and starts a search with the new size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code: 1 allocate, 2 enqueue, 3 clear |
| alloc_bytes | input | SIZE_W | Requested size in bytes |
| pnum_wr | input | 1 | Load the packet-number register |
| pnum_wdata | input | PN_W | Value for the packet-number register |
| ack_wr | input | 1 | Clear the done status |
| irq_en | input | 1 | Interrupt enable for done |
| busy | output | 1 | Command in progress |
| result_pn | output | PN_W | Last allocated packet number |
| result_fail | output | 1 | Pending request could not be satisfied yet |
| done | output | 1 | Allocation complete status |
| irq | output | 1 | Interrupt output |
| tx_ovf | output | 1 | Sticky queue overflow flag |
| tx_en | input | 1 | Transmit enable |
| half_duplex | input | 1 | Half-duplex mode |
| defer_ok | input | 1 | Deferral allows transmit |
| mac_ready | input | 1 | MAC takes the queue head |
| mac_valid | output | 1 | Queue head offered to the MAC |
| mac_pn | output | PN_W | Packet number at the queue head |
| rel_valid | input | 1 | Packet-done release strobe |
| rel_pn | input | PN_W | Packet number to free |

## Verification
The bench uses the default parameters: 8 pages of 256 bytes, a 12-bit byte count and a queue depth of 4. Eight pages let one 2048-byte request fill the whole memory, which shows that a clear command frees every page. The bench also splits the free pool into two runs that are each too short, so a request stays pending until a release joins them. A depth of 4 means the fifth enqueue hits the overflow path. A scoreboard follows the queue order through the gated MAC handoff.

// File: rtl/pa_pkg.sv
package pa_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_ALLOC = 3'd1,
        OP_ENQ   = 3'd2,
        OP_CLEAR = 3'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_ALLOC_WAIT = 2'd1,
        ST_CLEAR      = 2'd2
    } state_e;
endpackage

// File: rtl/pa_ctrl.sv
module pa_ctrl
    import pa_pkg::*;
#(
    parameter int SIZE_W     = 12,
    parameter int PAGE_BYTES = 256,
    parameter int PN_W       = 3,
    parameter int NEED_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [SIZE_W-1:0] alloc_bytes,
    input  logic              ack,
    input  logic              found,
    input  logic [PN_W-1:0]   found_pn,
    output logic [NEED_W-1:0] need,
    output logic              commit,
    output logic              clear_all,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [PN_W-1:0]   result_pn
);
    localparam int PG_SH = $clog2(PAGE_BYTES);

    state_e st, st_nxt;
    logic alloc_cmd;
    logic [NEED_W-1:0] need_raw, need_calc;

    assign alloc_cmd = cmd_valid && (cmd_op == OP_ALLOC);
    assign clear_all = cmd_valid && (cmd_op == OP_CLEAR);
    assign busy      = (st != ST_IDLE);

    // Round the byte count up to whole pages, with a minimum of one page.
    assign need_raw  = NEED_W'(alloc_bytes >> PG_SH) + NEED_W'(|alloc_bytes[PG_SH-1:0]);
    assign need_calc = (need_raw == '0) ? NEED_W'(1) : need_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        commit = 1'b0;
        if (clear_all) begin
            st_nxt = ST_CLEAR;
        end else if (alloc_cmd) begin
            st_nxt = ST_ALLOC_WAIT;
        end else begin
            unique case (st)
                ST_IDLE:       st_nxt = ST_IDLE;
                ST_ALLOC_WAIT: if (found) begin
                                   commit = 1'b1;
                                   st_nxt = ST_IDLE;
                               end
                ST_CLEAR:      st_nxt = ST_IDLE;
                default:       st_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            need      <= NEED_W'(1);
            done      <= 1'b0;
            fail      <= 1'b0;
            result_pn <= '0;
        end else if (clear_all) begin
            done      <= 1'b0;
            fail      <= 1'b0;
            result_pn <= '0;
        end else if (alloc_cmd) begin
            need <= need_calc;
            done <= 1'b0;
            fail <= 1'b0;
        end else if (commit) begin
            done      <= 1'b1;
            fail      <= 1'b0;
            result_pn <= found_pn;
        end else begin
            if (st == ST_ALLOC_WAIT) fail <= 1'b1;
            if (ack)                 done <= 1'b0;
        end
    end

    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_fail_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (st == ST_ALLOC_WAIT));
    assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_cmd && !clear_all) |=> (st == ST_ALLOC_WAIT && !done && !fail));
endmodule

// File: rtl/pa_page_map.sv
module pa_page_map #(
    parameter int NUM_PAGES = 8,
    parameter int PN_W      = 3,
    parameter int NEED_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic [NEED_W-1:0] need,
    input  logic              commit,
    input  logic              rel_valid,
    input  logic [PN_W-1:0]   rel_pn,
    output logic              found,
    output logic [PN_W-1:0]   found_pn
);
    logic [NUM_PAGES-1:0] used, take_mask, free_mask;
    logic [NEED_W-1:0]    run_len [NUM_PAGES];
    logic [NEED_W-1:0]    rel_len;
    logic                 fits;

    // Lowest-indexed contiguous run of free pages long enough for the request.
    always_comb begin
        found    = 1'b0;
        found_pn = '0;
        fits     = 1'b0;
        for (int s = 0; s < NUM_PAGES; s++) begin
            fits = (s + int'(need)) <= NUM_PAGES;
            for (int p = 0; p < NUM_PAGES; p++)
                if (p >= s && p < s + int'(need) && used[p]) fits = 1'b0;
            if (fits && !found) begin
                found    = 1'b1;
                found_pn = PN_W'(s);
            end
        end
    end

    assign rel_len = run_len[rel_pn];

    generate
        for (genvar g = 0; g < NUM_PAGES; g++) begin : g_mask
            assign take_mask[g] = (g >= int'(found_pn)) && (g < int'(found_pn) + int'(need));
            assign free_mask[g] = rel_valid && (g >= int'(rel_pn)) &&
                                  (g < int'(rel_pn) + int'(rel_len));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used <= '0;
            for (int i = 0; i < NUM_PAGES; i++) run_len[i] <= '0;
        end else if (clear_all) begin
            used <= '0;
            for (int i = 0; i < NUM_PAGES; i++) run_len[i] <= '0;
        end else begin
            used <= (used & ~free_mask) | (commit ? take_mask : '0);
            if (rel_valid) run_len[rel_pn] <= '0;
            if (commit)    run_len[found_pn] <= need;
        end
    end

    assert_take_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ((used & take_mask) == '0));
    assert_free_owned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((free_mask & ~used) == '0));
endmodule

// File: rtl/pa_tx_fifo.sv
module pa_tx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          full, push_ok;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; cnt <= '0; ovf <= 1'b0;
        end else if (clear) begin
            wp <= '0; rp <= '0; cnt <= '0; ovf <= 1'b0;
        end else begin
            if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)     rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(push_ok) - CW'(pop);
            if (push && full) ovf <= 1'b1;
        end
    end

    assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clear) |=> ovf);
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
    import pa_pkg::*;
#(
    parameter int NUM_PAGES  = 8,
    parameter int PAGE_BYTES = 256,
    parameter int SIZE_W     = 12,
    parameter int FIFO_DEPTH = 4,
    localparam int PN_W      = $clog2(NUM_PAGES),
    localparam int NEED_W    = SIZE_W - $clog2(PAGE_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [SIZE_W-1:0] alloc_bytes,
    input  logic              pnum_wr,
    input  logic [PN_W-1:0]   pnum_wdata,
    input  logic              ack_wr,
    input  logic              irq_en,
    output logic              busy,
    output logic [PN_W-1:0]   result_pn,
    output logic              result_fail,
    output logic              done,
    output logic              irq,
    output logic              tx_ovf,
    input  logic              tx_en,
    input  logic              half_duplex,
    input  logic              defer_ok,
    input  logic              mac_ready,
    output logic              mac_valid,
    output logic [PN_W-1:0]   mac_pn,
    input  logic              rel_valid,
    input  logic [PN_W-1:0]   rel_pn
);
    logic [NEED_W-1:0] need;
    logic              commit, clear_all, found, q_empty, q_pop, enq;
    logic [PN_W-1:0]   found_pn, pnum_reg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pnum_reg <= '0;
        else if (pnum_wr) pnum_reg <= pnum_wdata;
    end

    assign enq       = cmd_valid && (cmd_op == OP_ENQ);
    assign mac_valid = !q_empty && tx_en && (!half_duplex || defer_ok);
    assign q_pop     = mac_valid && mac_ready;
    assign irq       = done && irq_en;

    pa_ctrl #(.SIZE_W(SIZE_W), .PAGE_BYTES(PAGE_BYTES), .PN_W(PN_W), .NEED_W(NEED_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .alloc_bytes(alloc_bytes), .ack(ack_wr), .found(found), .found_pn(found_pn),
        .need(need), .commit(commit), .clear_all(clear_all), .busy(busy),
        .done(done), .fail(result_fail), .result_pn(result_pn)
    );

    pa_page_map #(.NUM_PAGES(NUM_PAGES), .PN_W(PN_W), .NEED_W(NEED_W)) u_map (
        .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .need(need), .commit(commit),
        .rel_valid(rel_valid), .rel_pn(rel_pn), .found(found), .found_pn(found_pn)
    );

    pa_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(PN_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(clear_all), .push(enq), .din(pnum_reg),
        .pop(q_pop), .dout(mac_pn), .empty(q_empty), .ovf(tx_ovf)
    );

    assert_handoff_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mac_valid |-> (tx_en && (!half_duplex || defer_ok)));
    assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

// File: tb/pkt_page_alloc_bench.sv
module pkt_page_alloc_bench;
    localparam int DEPTH = 4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cmd_valid = 0, pnum_wr = 0, ack_wr = 0, irq_en = 0;
    logic [2:0]  cmd_op = 0;
    logic [11:0] alloc_bytes = 0;
    logic [2:0]  pnum_wdata = 0, rel_pn = 0;
    logic        tx_en = 1, half_duplex = 0, defer_ok = 0, mac_ready = 1, rel_valid = 0;
    logic        busy, result_fail, done, irq, tx_ovf, mac_valid;
    logic [2:0]  result_pn, mac_pn;

    int n_vec = 0, n_bad = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    pkt_page_alloc u_pkt_page_alloc (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .alloc_bytes(alloc_bytes), .pnum_wr(pnum_wr), .pnum_wdata(pnum_wdata),
        .ack_wr(ack_wr), .irq_en(irq_en), .busy(busy), .result_pn(result_pn),
        .result_fail(result_fail), .done(done), .irq(irq), .tx_ovf(tx_ovf),
        .tx_en(tx_en), .half_duplex(half_duplex), .defer_ok(defer_ok),
        .mac_ready(mac_ready), .mac_valid(mac_valid), .mac_pn(mac_pn),
        .rel_valid(rel_valid), .rel_pn(rel_pn)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    task automatic send(input int op, input int bytes);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'(op); alloc_bytes = 12'(bytes);
        @(negedge clk);
        cmd_valid = 0; cmd_op = 0;
        #1;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic release_pn(input int pn);
        @(negedge clk);
        rel_valid = 1; rel_pn = 3'(pn);
        @(negedge clk);
        rel_valid = 0;
        #1;
    endtask

    // Driver: load the number, enqueue it, predict the queue contents.
    task automatic enq(input int pn);
        @(negedge clk);
        pnum_wr = 1; pnum_wdata = 3'(pn);
        @(negedge clk);
        pnum_wr = 0; cmd_valid = 1; cmd_op = 3'd2;
        if (exp_q.size() < DEPTH) exp_q.push_back(pn);
        @(negedge clk);
        cmd_valid = 0; cmd_op = 0;
        #1;
    endtask

    // Monitor: every handoff to the MAC is compared with the queue head (R6, R7).
    always begin
        @(negedge clk);
        #5;
        if (rst_n && mac_valid && mac_ready) begin
            if (exp_q.size() == 0) chk("R7 unexpected handoff", 1, 0);
            else chk("R6 handoff order", int'(mac_pn), exp_q.pop_front());
        end
    end

    initial begin
        #(20 * 50000);
        n_vec++; n_bad++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 irq", irq, 0);
        chk("R1 fail", result_fail, 0);
        chk("R1 ovf", tx_ovf, 0);
        chk("R1 mac_valid", mac_valid, 0);

        send(1, 0);
        chk("R2 busy after cmd", busy, 1);
        step();
        chk("R2 done zero-size", done, 1);
        chk("R2 result zero-size", result_pn, 0);
        chk("R2 busy cleared", busy, 0);
        chk("R4 irq masked", irq, 0);

        send(1, 257);
        chk("R5 done cleared by alloc", done, 0);
        step();
        chk("R2 result 257 bytes", result_pn, 1);

        send(1, 256);
        step();
        chk("R2 result 256 bytes", result_pn, 3);

        @(negedge clk); irq_en = 1; #1;
        chk("R4 irq enabled", irq, 1);
        @(negedge clk); ack_wr = 1;
        @(negedge clk); ack_wr = 0; #1;
        chk("R5 done after ack", done, 0);
        chk("R4 irq after ack", irq, 0);

        send(1, 1025);
        step();
        chk("R3 fail pending", result_fail, 1);
        chk("R3 busy pending", busy, 1);
        chk("R3 done pending", done, 0);
        release_pn(1);
        step();
        chk("R3 still split", result_fail, 1);
        release_pn(3);
        step();
        chk("R3 completes done", done, 1);
        chk("R9 merged run result", result_pn, 1);
        chk("R3 fail cleared", result_fail, 0);
        chk("R3 busy cleared", busy, 0);

        send(1, 1024);
        step();
        chk("R3 pending 4 pages", result_fail, 1);
        release_pn(3);
        step();
        chk("R9 bogus release ignored", result_fail, 1);
        chk("R9 bogus release busy", busy, 1);
        send(1, 512);
        chk("R12 restart done", done, 0);
        step();
        chk("R12 restart done set", done, 1);
        chk("R12 restart result", result_pn, 6);

        send(5, 0);
        chk("R11 undefined busy", busy, 0);
        chk("R11 undefined done", done, 1);
        chk("R11 undefined result", result_pn, 6);
        send(0, 0);
        chk("R11 nop done", done, 1);

        send(3, 0);
        chk("R10 clear busy", busy, 1);
        chk("R10 clear done", done, 0);
        step();
        chk("R10 clear one cycle", busy, 0);
        send(1, 2048);
        step();
        chk("R10 all pages free", done, 1);
        chk("R10 full memory result", result_pn, 0);

        @(negedge clk); tx_en = 0;
        enq(2); enq(5); enq(1); enq(7);
        chk("R7 tx disabled", mac_valid, 0);
        chk("R8 no ovf at depth", tx_ovf, 0);
        enq(3);
        chk("R8 overflow flag", tx_ovf, 1);
        @(negedge clk); tx_en = 1; half_duplex = 1; defer_ok = 0; #1;
        chk("R7 deferral blocks", mac_valid, 0);
        repeat (2) step();
        chk("R7 deferral still blocks", mac_valid, 0);
        @(negedge clk); defer_ok = 1;
        repeat (6) step();
        chk("R6 queue drained", exp_q.size(), 0);
        chk("R7 empty not valid", mac_valid, 0);
        chk("R8 ovf sticky", tx_ovf, 1);

        @(negedge clk); tx_en = 0;
        enq(4);
        send(3, 0);
        exp_q.delete();
        chk("R10 ovf cleared", tx_ovf, 0);
        @(negedge clk); tx_en = 1; half_duplex = 0; defer_ok = 0; #1;
        chk("R10 queue emptied", mac_valid, 0);
        enq(6);
        repeat (3) step();
        chk("R7 full duplex ignores deferral", exp_q.size(), 0);

        summary();
        $finish;
    end
endmodule